// File: doc/BRIEF.md
# Nibble to two-digit BCD converter

The block turns a 4-bit unsigned binary value (0 to 15) into a two-digit 8421 BCD result. The result is a 4-bit units digit and a single tens bit. The conversion has two steps. First, a magnitude comparator checks whether the value is above nine. Second, a 4-bit ripple adder adds six to the value only when it is above nine. The low four bits of the sum form the units digit, and the adder's carry-out forms the tens bit. The adder's carry-in is tied to zero.

By default the result passes through one output register stage. That stage loads a new result on a clock edge where `valid_i` is high. It raises `valid_o` one cycle after each accepted input. When `valid_i` is low, the stage keeps its previous digits. If the parameter `REG_OUT` is 0, the stage is removed: the outputs follow the input combinationally and `valid_o` mirrors `valid_i`.

Top module: `nib_to_bcd`

## Requirements
- R1: For an input from 0 to 9, the units digit equals the input and the tens bit is 0.
- R2: For an input from 10 to 15, the units digit equals the input minus 10 (0 to 5) and the tens bit is 1.
- R3: The switch point is exact: input 9 gives units 9 and tens 0; input 10 gives units 0 and tens 1.
- R4: With `REG_OUT`=1, an input presented with `valid_i` high at a rising clock edge appears on `units_o` and `tens_o` after that edge. At that edge `valid_o` goes to 1.
- R5: With `REG_OUT`=1, a clock edge with `valid_i` low leaves `units_o` and `tens_o` unchanged, whatever `bin_i` holds, and drives `valid_o` to 0.
- R6: While `rst_ni` is low, `units_o`, `tens_o` and `valid_o` are 0. The reset acts without waiting for a clock edge.
- R7: For every one of the 16 input codes, `units_o` is at most 9 and 10*`tens_o` + `units_o` equals the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `bin_i` as a value to convert |
| bin_i | input | 4 | Unsigned binary value, 0 to 15 |
| units_o | output | 4 | BCD units digit, 0 to 9 |
| tens_o | output | 1 | BCD tens digit, 0 or 1 |
| valid_o | output | 1 | Result on `units_o`/`tens_o` is new this cycle |

## Verification
A wrong comparator decision shows up in the very next result. Either the tens bit is wrong or the units digit goes outside 0 to 9. This appears for one specific code, such as 9 or 10, so every one of the 16 codes is applied and checked. A broken adder bit or carry chain corrupts only some codes, and only those codes show the error. An output stage that loads when `valid_i` is low, or mistimes `valid_o`, is caught in the cycle right after the first idle or accepted edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIG_W     = 4;
  localparam int unsigned BCD_LIMIT = 9;
  // amount that wraps (LIMIT+1) to zero with a carry out of DIG_W bits
  localparam int unsigned BCD_CORR  = (1 << DIG_W) - (BCD_LIMIT + 1);

  typedef struct packed {
    logic             tens;
    logic [DIG_W-1:0] units;
  } bcd_digit_t;
endpackage

// File: rtl/bcd_gt_cmp.sv
module bcd_gt_cmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  logic [W:0] gt_acc;
  logic [W:0] eq_acc;

  assign gt_acc[W] = 1'b0;
  assign eq_acc[W] = 1'b1;

  // MSB-first magnitude chain
  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign gt_acc[i] = gt_acc[i+1] | (eq_acc[i+1] & a_i[i] & ~b_i[i]);
    assign eq_acc[i] = eq_acc[i+1] & ~(a_i[i] ^ b_i[i]);
  end

  assign gt_o = gt_acc[0];
endmodule

// File: rtl/bcd_corr_add.sv
module bcd_corr_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  logic [W:0] c;

  assign c[0] = 1'b0;  // carry-in tied low

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign co_o = c[W];
endmodule

// File: rtl/nib_to_bcd.sv
module nib_to_bcd
  import bcd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DIG_W-1:0] bin_i,
  output logic [DIG_W-1:0] units_o,
  output logic             tens_o,
  output logic             valid_o
);
  localparam logic [DIG_W-1:0] LIMIT_C = DIG_W'(BCD_LIMIT);
  localparam logic [DIG_W-1:0] CORR_C  = DIG_W'(BCD_CORR);

  logic             gt;
  logic [DIG_W-1:0] corr_op;
  bcd_digit_t       res_c;

  bcd_gt_cmp #(.W(DIG_W)) u_cmp (
    .a_i  (bin_i),
    .b_i  (LIMIT_C),
    .gt_o (gt)
  );

  assign corr_op = CORR_C & {DIG_W{gt}};

  bcd_corr_add #(.W(DIG_W)) u_add (
    .a_i   (bin_i),
    .b_i   (corr_op),
    .sum_o (res_c.units),
    .co_o  (res_c.tens)
  );

  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_i <= LIMIT_C) |-> (!res_c.tens && res_c.units == bin_i)); // R1
  AST_HIGH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_i > LIMIT_C) |-> (res_c.tens && res_c.units == DIG_W'(bin_i - 4'd10))); // R2

  if (REG_OUT) begin : g_reg
    bcd_digit_t res_q;
    logic       vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) res_q <= res_c;
      end
    end

    assign units_o = res_q.units;
    assign tens_o  = res_q.tens;
    assign valid_o = vld_q;

    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(units_o) && $stable(tens_o))); // R5
    AST_UNITS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      units_o <= LIMIT_C); // R7
  end else begin : g_comb
    assign units_o = res_c.units;
    assign tens_o  = res_c.tens;
    assign valid_o = valid_i;
  end
endmodule

// File: tb/sim_nib_to_bcd.sv
module sim_nib_to_bcd;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] bin_i = 4'd0;
  logic [3:0] units_o;
  logic       tens_o;
  logic       valid_o;

  int total = 0;
  int bad = 0;

  nib_to_bcd #(.REG_OUT(1'b1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .bin_i(bin_i),
    .units_o(units_o), .tens_o(tens_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present value with valid for one edge, sample at the next falling edge
  task automatic push(int v);
    @(negedge clk_i);
    bin_i = 4'(v);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    valid_i = 1'b1; bin_i = 4'd15;
    repeat (2) @(negedge clk_i);
    check("R6 units", units_o, 0);
    check("R6 tens", tens_o, 0);
    check("R6 valid", valid_o, 0);
    rst_ni = 1'b1;
    valid_i = 1'b0;
  endtask

  task automatic t_low();
    for (int v = 0; v <= 9; v++) begin
      push(v);
      check("R1 units", units_o, v);
      check("R1 tens", tens_o, 0);
    end
  endtask

  task automatic t_high();
    for (int v = 10; v <= 15; v++) begin
      push(v);
      check("R2 units", units_o, v - 10);
      check("R2 tens", tens_o, 1);
    end
  endtask

  task automatic t_edge();
    push(9);
    check("R3 units@9", units_o, 9);
    check("R3 tens@9", tens_o, 0);
    push(10);
    check("R3 units@10", units_o, 0);
    check("R3 tens@10", tens_o, 1);
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    check("R4 idle valid", valid_o, 0);
    bin_i = 4'd7; valid_i = 1'b1;
    #1;
    check("R4 before edge units", units_o, 0);
    @(negedge clk_i);
    check("R4 valid", valid_o, 1);
    check("R4 units", units_o, 7);
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R4 valid drop", valid_o, 0);
  endtask

  task automatic t_hold();
    push(13);
    bin_i = 4'd2;
    repeat (2) @(negedge clk_i);
    check("R5 units", units_o, 3);
    check("R5 tens", tens_o, 1);
    check("R5 valid", valid_o, 0);
  endtask

  task automatic t_sum();
    for (int v = 15; v >= 0; v--) begin
      push(v);
      check("R7 range", int'(units_o <= 4'd9), 1);
      check("R7 value", 10 * tens_o + units_o, v);
    end
  endtask

  task automatic t_async_reset();
    push(14);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R6 async units", units_o, 0);
    check("R6 async tens", tens_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_low();
    t_high();
    t_edge();
    t_latency();
    t_hold();
    t_sum();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule